// File: doc/BRIEF.md
# Exact-Rank LRU Replacement Tracker

This block keeps the recency order of the ways in every set of a set-associative cache and names the way to evict when a line must be brought in. Each way of each set holds a binary rank: zero for the way touched most recently, the all-ones value for the way touched longest ago. The ranks of one set always form a permutation of 0..WAYS-1. The block holds no tags and no data. The surrounding cache reports each hit or fill by pulsing an access strobe with the set and the way. It asks for a victim by placing a set number on a query port, and it supplies a mask of the valid ways in that set.

An access moves the touched way to rank zero. Every way whose rank was below the touched way's old rank moves down by one, and ways that were already older keep their rank. The victim is normally the way whose rank is all ones. A free (invalid) way always takes precedence over that choice. A mode input replaces the recency choice with a pseudo-random way taken from a free-running shift register. Ranks continue to be updated in that mode.

Top module: `lru_age_unit`

## Requirements
- R1: After reset, way w of every set holds rank w, so with all ways valid the victim of every set is way WAYS-1.
- R2: One cycle after an access strobe, the accessed way of the named set holds rank zero and is not the recency victim (for WAYS greater than 1).
- R3: On an access, ways with a rank lower than the touched way's previous rank gain one, ways with a higher rank are unchanged, and ranks stay a permutation, so with all ways valid the victim is always the least recently accessed way.
- R4: Sets other than the accessed one, and all sets during cycles without an access strobe, keep their ranks.
- R5: When bit w of the valid mask is 0, way w counts as invalid. If any way is invalid, the victim is the invalid way with the lowest index, in either mode.
- R6: With the random-mode input at 1 and all ways valid, the victim is taken from the low bits of a 16-bit shift register that advances every cycle and never holds zero, so every way is chosen at about the same rate. Accesses still update the ranks in this mode.
- R7: With WAYS=2 the rank is one bit: the way just used holds 0, the other way holds 1 and is the victim.
- R8: The victim is a combinational function of the query set, the mask, the mode and the stored ranks, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rand_mode | input | 1 | 1 selects pseudo-random victim choice |
| acc_valid | input | 1 | Hit or fill strobe |
| acc_set | input | $clog2(SETS) | Set of the access |
| acc_way | input | $clog2(WAYS) | Way of the access |
| vic_set | input | $clog2(SETS) | Set being queried for a victim |
| valid_mask | input | WAYS | Valid bit per way of the queried set |
| victim_way | output | $clog2(WAYS) | Way to replace |

## Verification
A corrupted rank in a set shows up at the victim port the first time that set is queried. If two ways share the oldest rank, or no way holds it, the port names a way that is not the least recently used one. Because the query is combinational, the error appears in the cycle right after the faulty update. The bench queries every set after each access, so a bad update is caught before the next access. Wrong ageing of the untouched ways shows up a few accesses later, when the recency order the bench tracks in a list disagrees with the victim the block reports.

// File: rtl/lru_age_unit.sv
module lru_age_unit #(
  parameter int WAYS = 4,
  parameter int SETS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rand_mode,
  input  logic                     acc_valid,
  input  logic [$clog2(SETS)-1:0]  acc_set,
  input  logic [$clog2(WAYS)-1:0]  acc_way,
  input  logic [$clog2(SETS)-1:0]  vic_set,
  input  logic [WAYS-1:0]          valid_mask,
  output logic [$clog2(WAYS)-1:0]  victim_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = {WAY_W{1'b1}};
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [15:0] SEED = 16'hACE1;

  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAYS-1:0][WAY_W-1:0] row_cur, row_nxt, row_q;
  logic [WAYS-1:0] lru_hot;
  logic [WAY_W-1:0] lru_way, inv_way;
  logic has_inv;
  logic [15:0] lfsr_q;

  assign row_cur = age_q[acc_set];
  assign row_q   = age_q[vic_set];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == acc_way)
        row_nxt[w] = '0;
      else if (row_cur[w] < row_cur[acc_way])
        row_nxt[w] = row_cur[w] + 1'b1;
      else
        row_nxt[w] = row_cur[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (acc_valid) begin
      age_q[acc_set] <= row_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0000);
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lru_hot[w] = (row_q[w] == OLDEST);
      if (lru_hot[w]) lru_way = WAY_W'(w);
    end
  end

  always_comb begin
    has_inv = 1'b0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_mask[w]) begin
        has_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
  end

  assign victim_way = has_inv   ? inv_way :
                      rand_mode ? lfsr_q[WAY_W-1:0] : lru_way;

  p_touch_young_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> age_q[$past(acc_set)][$past(acc_way)] == '0);

  p_single_oldest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_hot) == 1);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(age_q));

  p_invalid_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_mask) |-> !valid_mask[victim_way]);

  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);
endmodule

// File: tb/sim_lru_age_unit.sv
module sim_lru_age_unit;
  localparam int WAYS = 4;
  localparam int SETS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rand_mode = 1'b0;
  logic acc_valid = 1'b0;
  logic [1:0] acc_set = '0, vic_set = '0;
  logic [1:0] acc_way = '0;
  logic [3:0] valid_mask = 4'hF;
  logic [1:0] victim_way;

  logic acc2_valid = 1'b0;
  logic acc2_way = 1'b0;
  logic [1:0] mask2 = 2'b11;
  logic victim2;

  int n_vec = 0, n_bad = 0;
  int order [SETS][WAYS];
  int cnt [WAYS];
  bit done = 0;

  always #4 clk = ~clk;

  lru_age_unit #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .rand_mode(rand_mode), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_way(acc_way), .vic_set(vic_set),
    .valid_mask(valid_mask), .victim_way(victim_way));

  lru_age_unit #(.WAYS(2), .SETS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .rand_mode(1'b0), .acc_valid(acc2_valid),
    .acc_set(1'b0), .acc_way(acc2_way), .vic_set(1'b0),
    .valid_mask(mask2), .victim_way(victim2));

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_vic(input int s, input int m);
    for (int w = 0; w < WAYS; w++)
      if (!m[w]) return w;
    return order[s][WAYS-1];
  endfunction

  task automatic touch(input int s, input int w);
    int k;
    @(negedge clk);
    acc_valid = 1'b1; acc_set = 2'(s); acc_way = 2'(w);
    @(negedge clk);
    acc_valid = 1'b0;
    k = 0;
    while (order[s][k] != w) k++;
    for (int j = k; j > 0; j--) order[s][j] = order[s][j-1];
    order[s][0] = w;
  endtask

  task automatic check_all_sets(input string req);
    for (int s = 0; s < SETS; s++) begin
      vic_set = 2'(s);
      #1;
      chk(req, int'(victim_way), exp_vic(s, 15));
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) order[s][w] = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset ranks
    check_all_sets("R1");
    #1 chk("R1/R7 two-way reset", int'(victim2), 1);

    // R2 R3 R4 R8: arithmetic access pattern, every set checked after each access
    for (int i = 0; i < 300; i++) begin
      int s, w;
      s = (i * 3 + i / 5) % SETS;
      w = ((i * 7) ^ (i >> 2)) % WAYS;
      touch(s, w);
      vic_set = 2'(s); #1;
      if (victim_way == 2'(w)) chk("R2 touched way not victim", int'(victim_way), order[s][WAYS-1]);
      check_all_sets("R3/R4/R8");
    end

    // R4: idle cycles change nothing
    repeat (10) @(negedge clk);
    check_all_sets("R4 idle");

    // R5: every mask on every set
    for (int s = 0; s < SETS; s++)
      for (int m = 0; m < 16; m++) begin
        vic_set = 2'(s); valid_mask = 4'(m); #1;
        chk("R5", int'(victim_way), exp_vic(s, m));
      end
    valid_mask = 4'hF;

    // R6: random mode spread
    for (int w = 0; w < WAYS; w++) cnt[w] = 0;
    rand_mode = 1'b1; vic_set = 2'd0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      cnt[victim_way]++;
    end
    for (int w = 0; w < WAYS; w++)
      chk("R6 share in range", int'(cnt[w] >= 60 && cnt[w] <= 140), 1);
    valid_mask = 4'b1011; #1;
    chk("R5 invalid beats random", int'(victim_way), 2);
    valid_mask = 4'hF;
    touch(1, 2); touch(1, 0); touch(3, 3);
    rand_mode = 1'b0;
    check_all_sets("R6 ranks kept in random mode");

    // R7: two-way
    @(negedge clk); acc2_valid = 1'b1; acc2_way = 1'b1;
    @(negedge clk); acc2_valid = 1'b0; #1;
    chk("R7 after way1", int'(victim2), 0);
    @(negedge clk); acc2_valid = 1'b1; acc2_way = 1'b0;
    @(negedge clk); acc2_valid = 1'b0; #1;
    chk("R7 after way0", int'(victim2), 1);
    @(negedge clk); acc2_valid = 1'b1; acc2_way = 1'b0;
    @(negedge clk); acc2_valid = 1'b0; #1;
    chk("R7 repeat way0", int'(victim2), 1);
    mask2 = 2'b10; #1;
    chk("R7/R5 invalid way0", int'(victim2), 0);

    summary();
  end
endmodule